// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block gathers the data bytes of one serial write transaction into a small page buffer and then transfers them into a byte-wide memory model. A transaction opens with a start address. Every accepted byte lands in the buffer slot selected by a 4-bit in-page offset, and that offset advances after each byte. The upper address bits stay fixed, so a long transaction wraps around inside its page and later bytes replace earlier ones.

The buffer is copied to memory only when the transaction ends with a Stop. The copy runs one slot per cycle, and only the slots written in this transaction are copied. The block then reports busy for a fixed, parameterised write-cycle time. If the transaction is cut off by a repeated Start instead, the buffer marks are dropped and nothing is written. When the write-protect input is high at the Stop, the copy writes nothing but the full busy time still applies. While busy, the block ignores every request, just as the serial front end stops acknowledging during a write cycle.

The controller has four states: IDLE, COLLECT, COMMIT and HOLD. Its transitions are:
- IDLE→COLLECT on a start request.
- COLLECT→IDLE on a repeated Start (abort), or on a Stop when no byte has arrived (empty stop).
- COLLECT→COMMIT on a Stop when at least one byte has arrived (commit).
- COMMIT→HOLD after the last slot has been scanned (scan done).
- HOLD→IDLE when the write-cycle timer expires (cycle done).

Top module: `page_commit_top`

## Requirements
- R1: In IDLE, a `start_load` pulse latches the page as `start_addr[7:4]` and the offset as `start_addr[3:0]`. The first byte of the transaction goes to memory address page*16 + offset.
- R2: Each accepted byte advances only the 4-bit offset, wrapping from 15 to 0. The page bits never change inside a transaction.
- R3: When more than 16 bytes arrive before the Stop, a later byte overwrites the slot of an earlier one. Each location receives the last byte sent to it.
- R4: Memory is not changed while bytes are being collected. The commit starts only after a Stop.
- R5: Only slots written in the current transaction are committed. All other addresses of the page keep their previous contents.
- R6: Busy rises in the cycle after the Stop is captured and stays high for exactly `WC_CYCLES` cycles. The time is the same for one byte or a full page.
- R7: Write protect is sampled with the Stop. When it is 1, no memory location changes, yet busy still lasts the full `WC_CYCLES`.
- R8: A repeated Start during COLLECT discards the collected bytes, writes nothing and raises no busy. It takes priority over a Stop in the same cycle, and a Stop takes priority over a byte in the same cycle.
- R9: While busy, `start_load`, `byte_valid` and `stop_pulse` are ignored. They neither extend busy nor change memory.
- R10: A Stop that arrives with no byte collected returns to IDLE without busy and without any write.
- R11: The memory write strobe is asserted only while busy.
- R12: After reset, busy and the write strobe are low and every memory location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_load | input | 1 | Opens a write transaction (accepted in IDLE only) |
| start_addr | input | 8 | Start address: page in [7:4], offset in [3:0] |
| byte_valid | input | 1 | One data byte is present this cycle |
| byte_data | input | 8 | Data byte |
| stop_pulse | input | 1 | Transaction ended by Stop |
| restart_pulse | input | 1 | Transaction aborted by repeated Start |
| wp_in | input | 1 | Write protect, sampled with the Stop |
| rd_addr | input | 8 | Memory model read address |
| rd_data | output | 8 | Memory model read data (combinational) |
| busy | output | 1 | Commit or write-cycle hold in progress |
| mem_we | output | 1 | Memory write strobe during commit |
| mem_addr | output | 8 | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The hardest situation to reach is a buffer whose marks form a broken pattern after a wrap. In that case some slots of the page have been overwritten, some were written once and others were never touched, all in one transaction. Random transactions of 0 to 20 bytes at random start offsets produce these patterns, and directed runs at offset 10 with 20 bytes and with 16 bytes pin down the exact wrap points. A second hard case is a request arriving in the middle of the busy window. A directed sequence drives start, bytes and Stop while busy is high and counts the busy cycles without a break.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_HOLD    = 2'd3
    } pcw_state_e;
endpackage

// File: rtl/pcw_page_buf.sv
module pcw_page_buf #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int OFF_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_all,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_mark,
    output logic              marks_any
);
    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mark_q;
    logic [PAGE_BYTES-1:0] hit;

    // one write-select line per slot
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_off == OFF_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                slot_q[i] <= '0;
            end
            mark_q <= '0;
        end else begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (hit[i]) begin
                    slot_q[i] <= wr_data;
                end
            end
            if (clr_all) begin
                mark_q <= '0;
            end else begin
                mark_q <= mark_q | hit;
            end
        end
    end

    assign rd_data   = slot_q[rd_off];
    assign rd_mark   = mark_q[rd_off];
    assign marks_any = |mark_q;

    // R8
    marks_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> !marks_any);
endmodule

// File: rtl/pcw_cycle_timer.sv
module pcw_cycle_timer #(
    parameter int CYCLES = 64,
    parameter int CNT_W  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pcw_mem_model.sv
module pcw_mem_model #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= '0;
            end
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/page_commit_top.sv
module page_commit_top #(
    parameter int DATA_W     = 8,
    parameter int MEM_DEPTH  = 256,
    parameter int PAGE_BYTES = 16,
    parameter int WC_CYCLES  = 250000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_load,
    input  logic [$clog2(MEM_DEPTH)-1:0] start_addr,
    input  logic                         byte_valid,
    input  logic [DATA_W-1:0]            byte_data,
    input  logic                         stop_pulse,
    input  logic                         restart_pulse,
    input  logic                         wp_in,
    input  logic [$clog2(MEM_DEPTH)-1:0] rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         busy,
    output logic                         mem_we,
    output logic [$clog2(MEM_DEPTH)-1:0] mem_addr,
    output logic [DATA_W-1:0]            mem_wdata
);
    import pcw_pkg::*;

    localparam int ADDR_W      = $clog2(MEM_DEPTH);
    localparam int OFF_W       = $clog2(PAGE_BYTES);
    localparam int PAGE_W      = ADDR_W - OFF_W;
    // the commit scan runs inside the hold window, so the window covers it
    localparam int HOLD_CYCLES = (WC_CYCLES > PAGE_BYTES) ? WC_CYCLES : PAGE_BYTES + 1;
    localparam int CNT_W       = $clog2(HOLD_CYCLES + 1);

    pcw_state_e        state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  off_q;
    logic [OFF_W-1:0]  scan_q;
    logic              wp_q;

    logic              ev_abort, ev_stop, ev_byte, scan_last;
    logic              buf_wr, buf_clr, tmr_load, tmr_expired;
    logic [DATA_W-1:0] slot_data;
    logic              slot_mark, buf_any;

    // event priority inside COLLECT: abort, then stop, then byte
    assign ev_abort  = restart_pulse;
    assign ev_stop   = stop_pulse && !restart_pulse;
    assign ev_byte   = byte_valid && !stop_pulse && !restart_pulse;
    assign scan_last = (scan_q == OFF_W'(PAGE_BYTES - 1));

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_load) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (ev_abort)      state_d = ST_IDLE;
                else if (ev_stop)  state_d = buf_any ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: begin
                if (scan_last) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        busy     = 1'b0;
        buf_wr   = 1'b0;
        buf_clr  = 1'b0;
        tmr_load = 1'b0;
        mem_we   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_COLLECT: begin
                buf_wr   = ev_byte;
                buf_clr  = ev_abort;
                tmr_load = ev_stop && buf_any;
            end
            ST_COMMIT: begin
                busy    = 1'b1;
                mem_we  = slot_mark && !wp_q;
                buf_clr = scan_last;
            end
            ST_HOLD: begin
                busy = 1'b1;
            end
        endcase
    end

    assign mem_addr  = {page_q, scan_q};
    assign mem_wdata = slot_data;

    // address, scan and protect registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
            scan_q <= '0;
            wp_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_load) begin
                page_q <= start_addr[ADDR_W-1:OFF_W];
                off_q  <= start_addr[OFF_W-1:0];
            end
            if (buf_wr) begin
                off_q <= off_q + OFF_W'(1);
            end
            if (tmr_load) begin
                scan_q <= '0;
                wp_q   <= wp_in;
            end else if (state_q == ST_COMMIT) begin
                scan_q <= scan_q + OFF_W'(1);
            end
        end
    end

    pcw_page_buf #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES),
        .OFF_W      (OFF_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (buf_wr),
        .wr_off    (off_q),
        .wr_data   (byte_data),
        .clr_all   (buf_clr),
        .rd_off    (scan_q),
        .rd_data   (slot_data),
        .rd_mark   (slot_mark),
        .marks_any (buf_any)
    );

    pcw_cycle_timer #(
        .CYCLES (HOLD_CYCLES),
        .CNT_W  (CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    pcw_mem_model #(
        .DEPTH  (MEM_DEPTH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // busy-window length observer for the checks below
    logic [CNT_W:0] busy_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run_q <= '0;
        else if (busy) busy_run_q <= busy_run_q + (CNT_W+1)'(1);
        else           busy_run_q <= '0;
    end

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run_q == (CNT_W+1)'(HOLD_CYCLES));

    // R2
    off_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && ev_byte)
        |=> (off_q == $past(off_q) + OFF_W'(1)) && (page_q == $past(page_q)));

    // R11
    we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R9
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> state_q != ST_COLLECT);

    // R10
    empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && ev_stop && !buf_any) |=> !busy);
endmodule

// File: tb/tb_page_commit_top.sv
module tb_page_commit_top;
    localparam int WC    = 40;
    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_load = 1'b0;
    logic [7:0] start_addr = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       stop_pulse = 1'b0;
    logic       restart_pulse = 1'b0;
    logic       wp_in = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy, mem_we;
    logic [7:0] mem_addr, mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] exp_mem [DEPTH];
    logic [7:0] txd [32];

    page_commit_top #(
        .DATA_W(8), .MEM_DEPTH(DEPTH), .PAGE_BYTES(16), .WC_CYCLES(WC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_load(start_load), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop_pulse(stop_pulse),
        .restart_pulse(restart_pulse), .wp_in(wp_in), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference: page buffer with marks, committed on stop without protect
    task automatic model_txn(input logic [7:0] addr, input int n, input bit wp, input bit use_stop);
        logic [7:0] pbuf [16];
        bit         mk [16];
        logic [3:0] off;
        for (int j = 0; j < 16; j++) begin
            mk[j] = 1'b0;
            pbuf[j] = '0;
        end
        off = addr[3:0];
        for (int i = 0; i < n; i++) begin
            pbuf[off] = txd[i];
            mk[off] = 1'b1;
            off = off + 4'd1;
        end
        if (use_stop && !wp) begin
            for (int j = 0; j < 16; j++) begin
                if (mk[j]) exp_mem[{addr[7:4], 4'(j)}] = pbuf[j];
            end
        end
    endtask

    task automatic count_busy(inout int cnt);
        while (busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic run_txn(input logic [7:0] addr, input int n, input bit wp,
                           input bit use_stop, input bit peek, output int busy_n);
        @(negedge clk);
        start_load = 1'b1;
        start_addr = addr;
        wp_in = wp;
        @(negedge clk);
        start_load = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1;
            byte_data = txd[i];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        if (peek) begin
            rd_addr = addr;
            #1;
            chk(rd_data == exp_mem[addr], "R4 memory unchanged before stop", rd_data, exp_mem[addr]);
        end
        if (use_stop) stop_pulse = 1'b1;
        else          restart_pulse = 1'b1;
        @(negedge clk);
        stop_pulse = 1'b0;
        restart_pulse = 1'b0;
        busy_n = 0;
        count_busy(busy_n);
    endtask

    task automatic check_page(input logic [7:0] addr, input string req);
        for (int j = 0; j < 16; j++) begin
            rd_addr = {addr[7:4], 4'(j)};
            #1;
            chk(rd_data == exp_mem[rd_addr], req, rd_data, exp_mem[rd_addr]);
        end
    endtask

    task automatic full_txn(input logic [7:0] addr, input int n, input bit wp,
                            input bit use_stop, input string req);
        int bn;
        int eb;
        run_txn(addr, n, wp, use_stop, 1'b0, bn);
        model_txn(addr, n, wp, use_stop);
        eb = (use_stop && n > 0) ? WC : 0;
        chk(bn == eb, {req, " busy length"}, bn, eb);
        check_page(addr, req);
    endtask

    initial begin
        int unsigned seed;
        int bn;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk(busy == 1'b0, "R12 busy after reset", busy, 0);
        chk(mem_we == 1'b0, "R12 write strobe after reset", mem_we, 0);
        check_page(8'h00, "R12 memory zero after reset");
        check_page(8'hF0, "R12 memory zero after reset");

        // R1 / R6: single byte
        txd[0] = 8'hA5;
        full_txn(8'h25, 1, 1'b0, 1'b1, "R1 R6 single byte at 0x25");

        // R5: partial page keeps old contents; first fill page 0x30
        for (int i = 0; i < 16; i++) txd[i] = 8'(8'h10 + i);
        full_txn(8'h30, 16, 1'b0, 1'b1, "R6 full page 0x30");
        txd[0] = 8'hC1; txd[1] = 8'hC2; txd[2] = 8'hC3;
        full_txn(8'h35, 3, 1'b0, 1'b1, "R5 partial page keeps neighbours");

        // R2: wrap from offset 10 over the page end
        for (int i = 0; i < 16; i++) txd[i] = 8'(8'h60 + i);
        full_txn(8'h4A, 16, 1'b0, 1'b1, "R2 wrap inside page 0x40");
        rd_addr = 8'h50;
        #1;
        chk(rd_data == 8'h00, "R2 next page untouched", rd_data, 0);

        // R3: 20 bytes, the last ones overwrite the first
        for (int i = 0; i < 20; i++) txd[i] = 8'(8'h80 + i);
        full_txn(8'h6A, 20, 1'b0, 1'b1, "R3 overwrite after 20 bytes");
        rd_addr = 8'h6A;
        #1;
        chk(rd_data == 8'h90, "R3 slot 10 holds byte 16", rd_data, 8'h90);

        // R4: memory unchanged while collecting
        txd[0] = 8'h5A; txd[1] = 8'h5B;
        run_txn(8'h30, 2, 1'b0, 1'b1, 1'b1, bn);
        model_txn(8'h30, 2, 1'b0, 1'b1);
        chk(bn == WC, "R4 busy after stop", bn, WC);
        check_page(8'h30, "R4 commit after stop");

        // R7: write protect
        for (int i = 0; i < 8; i++) txd[i] = 8'hEE;
        full_txn(8'h30, 8, 1'b1, 1'b1, "R7 protected write changes nothing");

        // R8: abort by repeated start
        for (int i = 0; i < 5; i++) txd[i] = 8'h77;
        full_txn(8'h40, 5, 1'b0, 1'b0, "R8 aborted transaction");
        txd[0] = 8'h12;
        full_txn(8'h41, 1, 1'b0, 1'b1, "R8 marks cleared after abort");

        // R10: stop with no bytes
        full_txn(8'h90, 0, 1'b0, 1'b1, "R10 empty stop");

        // R9: requests during busy are ignored
        txd[0] = 8'h3C;
        @(negedge clk);
        start_load = 1'b1; start_addr = 8'hA0; wp_in = 1'b0;
        @(negedge clk);
        start_load = 1'b0; byte_valid = 1'b1; byte_data = 8'h3C;
        @(negedge clk);
        byte_valid = 1'b0; stop_pulse = 1'b1;
        @(negedge clk);
        stop_pulse = 1'b0;
        exp_mem[8'hA0] = 8'h3C;
        bn = 0;
        for (int k = 0; k < 6; k++) begin
            if (busy) bn++;
            start_load = (k == 0); start_addr = 8'hB3;
            byte_valid = (k >= 1 && k <= 3); byte_data = 8'hDD;
            stop_pulse = (k == 4);
            @(negedge clk);
        end
        start_load = 1'b0; byte_valid = 1'b0; stop_pulse = 1'b0;
        count_busy(bn);
        chk(bn == WC, "R9 busy not extended", bn, WC);
        check_page(8'hB0, "R9 ignored bytes not written");
        check_page(8'hA0, "R9 committed byte");
        @(negedge clk);
        chk(busy == 1'b0, "R9 no second busy window", busy, 0);

        // random mix
        for (int t = 0; t < 30; t++) begin
            logic [7:0] a;
            int n;
            bit wp, st;
            a  = 8'($urandom);
            n  = $urandom_range(0, 20);
            wp = ($urandom_range(0, 4) == 0);
            st = ($urandom_range(0, 3) != 0);
            for (int i = 0; i < n; i++) txd[i] = 8'($urandom);
            full_txn(a, n, wp, st, "R3 R5 R7 R8 random transaction");
        end

        // R11: no strobe while idle
        chk(mem_we == 1'b0, "R11 strobe low when idle", mem_we, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule